// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Hub

This block holds the two data queues of a serial peripheral controller and turns their occupancy into the signals that software and a DMA engine react to. It has a transmit queue, which the bus fills and the serial engine drains. It has a receive queue, which the serial engine fills and the bus drains. From the two occupancy counts it derives a six-bit status word, five interrupt causes and two DMA request lines. Each cause has a raw view and a masked view, and the masked causes are combined into one interrupt line.

The serial engine takes transmit words over a valid/ready stream. `tx_out_valid` is high while the transmit queue holds a word. A word leaves the queue on a clock edge where both `tx_out_valid` and `tx_out_ready` are high. `tx_out_ready` without `tx_out_valid` has no effect. The other three data paths are strobes with no back-pressure:
- the bus transmit push,
- the engine receive push,
- the bus receive pop.

Misuse of a strobe raises a sticky error cause instead of stalling. Dropping `enable` empties both queues. The threshold registers accept writes only while the unit is disabled.

Top module: `spi_fifo_hub`

## Requirements
- R1: After reset both levels are 0. `status` reads 0x0C: bit 2 is transmit queue empty and bit 3 is receive queue empty. `raw_irq` reads 0x01, and `irq`, `tx_dma_req` and `rx_dma_req` are low when the mask and DMA enables are zero.
- R2: Each queue returns words in the order they were written. `tx_level` and `rx_level` report the occupancy, from 0 to DEPTH, one cycle after each accepted push or pop.
- R3: A transmit push while the transmit queue holds DEPTH words drops the word and leaves the level and the head word unchanged. It also sets raw cause bit 1 (transmit overflow), which stays set until cleared.
- R4: A receive pop from an empty receive queue returns 0 on `rx_rd_data` and sets sticky raw cause bit 2 (receive underflow).
- R5: A receive push while the receive queue holds DEPTH words drops the word and sets sticky raw cause bit 3 (receive overflow).
- R6: Raw cause bit 4 is high exactly when `rx_level` is strictly greater than the receive threshold, so a threshold of N-1 fires at N words.
- R7: Raw cause bit 0 is high exactly when `tx_level` is at or below the transmit threshold.
- R8: A write to the clear port acts as follows:
  - clear bit 0 clears all sticky causes;
  - bit 1 clears receive underflow;
  - bit 2 clears receive overflow;
  - bit 3 clears transmit overflow.

  A new error event in the same cycle as its clear leaves the cause set.
- R9: `masked_irq` is `raw_irq` ANDed with `irq_mask`, and `irq` is high when any masked bit is high.
- R10: While `enable` is low, both queues are empty one cycle later. Pushes are ignored without raising overflow.
- R11: A threshold write is taken only while `enable` is low. A write while enabled leaves the threshold unchanged.
- R12: The DMA requests are both gated by `enable`.
  - `rx_dma_req` is high when `dma_en` bit 0 is set and `rx_level` is at least `rx_dma_lvl`+1.
  - `tx_dma_req` is high when `dma_en` bit 1 is set and `tx_level` is at most `tx_dma_lvl`.
- R13: The status bits are:
  - bit 0: busy, which is `enable` AND (`engine_busy` OR transmit queue not empty);
  - bit 1: transmit full;
  - bit 4: receive full;
  - bit 5: `target_tx_busy` as driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Unit enable; low flushes both queues |
| tx_thr_we | input | 1 | Transmit threshold write strobe |
| tx_thr_wdata | input | LVL_W | Transmit threshold value |
| rx_thr_we | input | 1 | Receive threshold write strobe |
| rx_thr_wdata | input | LVL_W | Receive threshold value |
| irq_mask | input | 5 | Per-cause interrupt mask |
| clr_we | input | 1 | Clear write strobe |
| clr_data | input | 4 | Clear write data |
| dma_en | input | 2 | Bit 0 receive DMA enable, bit 1 transmit DMA enable |
| tx_dma_lvl | input | LVL_W | Transmit DMA watermark |
| rx_dma_lvl | input | LVL_W | Receive DMA watermark |
| engine_busy | input | 1 | Serial engine is shifting |
| target_tx_busy | input | 1 | Target-mode transmitter busy |
| tx_push | input | 1 | Bus transmit push strobe |
| tx_push_data | input | DW | Bus transmit word |
| tx_out_valid | output | 1 | Transmit head word available |
| tx_out_data | output | DW | Transmit head word |
| tx_out_ready | input | 1 | Engine takes the head word |
| rx_push | input | 1 | Engine receive push strobe |
| rx_push_data | input | DW | Engine receive word |
| rx_pop | input | 1 | Bus receive pop strobe |
| rx_rd_data | output | DW | Receive head word, 0 when empty |
| tx_level | output | LVL_W | Transmit occupancy |
| rx_level | output | LVL_W | Receive occupancy |
| status | output | 6 | Status word |
| raw_irq | output | 5 | Unmasked causes |
| masked_irq | output | 5 | Masked causes |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench first checks the strict comparison on the receive threshold. A design that used greater-or-equal would raise the cause one word early, at three words instead of four with a threshold of 3. At full depth it pushes once more into each queue. A design that let the extra word through would corrupt the head or push the level past DEPTH. It also raises an overflow in the same cycle as its clear, and a design that gave the clear priority would lose that error. It writes the thresholds while enabled, where a missing lock would move the receive cause. It probes the receive DMA boundary with a watermark equal to the level, where an off-by-one comparison would request a word that is not there. It also pushes into a disabled unit, which a design that forgot to hold the queues empty would accept.

// File: rtl/spi_fifo_hub_pkg.sv
package spi_fifo_hub_pkg;
  // status word positions
  localparam int ST_W        = 6;
  localparam int ST_BUSY     = 0;
  localparam int ST_TX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_RX_EMPTY = 3;
  localparam int ST_RX_FULL  = 4;
  localparam int ST_TGT_BUSY = 5;

  // interrupt cause positions (shared by mask, raw and masked views)
  localparam int IRQ_W       = 5;
  localparam int IRQ_TX_LOW  = 0;
  localparam int IRQ_TX_OVF  = 1;
  localparam int IRQ_RX_UDF  = 2;
  localparam int IRQ_RX_OVF  = 3;
  localparam int IRQ_RX_HIGH = 4;

  // causes that latch until cleared
  localparam logic [IRQ_W-1:0] STICKY_SET = 5'b01110;

  // clear port positions
  localparam int CLR_W      = 4;
  localparam int CLR_ALL    = 0;
  localparam int CLR_RX_UDF = 1;
  localparam int CLR_RX_OVF = 2;
  localparam int CLR_TX_OVF = 3;

  // DMA enable positions
  localparam int DMA_RX = 0;
  localparam int DMA_TX = 1;
endpackage

// File: rtl/sfh_fifo.sv
module sfh_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    head,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  output logic             overflow_evt,
  output logic             underflow_evt
);
  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;
  logic             do_push, do_pop;

  assign full          = (count == LVL_W'(DEPTH));
  assign empty         = (count == '0);
  assign do_push       = push & ~full & ~flush;
  assign do_pop        = pop & ~empty & ~flush;
  assign overflow_evt  = push & full & ~flush;
  assign underflow_evt = pop & empty & ~flush;
  assign head          = mem[rd_ptr];
  assign level         = count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R10

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (level == $past(level))); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LVL_W'(DEPTH))); // R2
endmodule

// File: rtl/sfh_irq.sv
module sfh_irq
  import spi_fifo_hub_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic [IRQ_W-1:0] evt,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_data,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  logic [IRQ_W-1:0] sticky_q, sticky_d, clr_vec, lvl_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_we) begin
      if (clr_data[CLR_ALL])    clr_vec = STICKY_SET;
      if (clr_data[CLR_RX_UDF]) clr_vec[IRQ_RX_UDF] = 1'b1;
      if (clr_data[CLR_RX_OVF]) clr_vec[IRQ_RX_OVF] = 1'b1;
      if (clr_data[CLR_TX_OVF]) clr_vec[IRQ_TX_OVF] = 1'b1;
    end
    // a fresh event wins over a clear in the same cycle
    sticky_d = (sticky_q & ~clr_vec) | (evt & STICKY_SET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  always_comb begin
    lvl_vec = '0;
    lvl_vec[IRQ_TX_LOW]  = (tx_level <= tx_thr);
    lvl_vec[IRQ_RX_HIGH] = (rx_level > rx_thr);
  end

  assign raw    = sticky_q | lvl_vec;
  assign masked = raw & mask;
  assign irq    = |masked;

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R8

  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[CLR_ALL] && ((evt & STICKY_SET) == '0))
      |=> ((sticky_q & STICKY_SET) == '0)); // R8
endmodule

// File: rtl/sfh_dma.sv
module sfh_dma
  import spi_fifo_hub_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             enable,
  input  logic [1:0]       dma_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] rx_lvl,
  output logic             tx_req,
  output logic             rx_req
);
  logic [LVL_W:0] rx_need;

  assign rx_need = {1'b0, rx_lvl} + 1'b1;
  assign rx_req  = enable & dma_en[DMA_RX] & ({1'b0, rx_level} >= rx_need);
  assign tx_req  = enable & dma_en[DMA_TX] & (tx_level <= tx_lvl);
endmodule

// File: rtl/spi_fifo_hub.sv
module spi_fifo_hub
  import spi_fifo_hub_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tx_thr_we,
  input  logic [LVL_W-1:0] tx_thr_wdata,
  input  logic             rx_thr_we,
  input  logic [LVL_W-1:0] rx_thr_wdata,
  input  logic [4:0]       irq_mask,
  input  logic             clr_we,
  input  logic [3:0]       clr_data,
  input  logic [1:0]       dma_en,
  input  logic [LVL_W-1:0] tx_dma_lvl,
  input  logic [LVL_W-1:0] rx_dma_lvl,
  input  logic             engine_busy,
  input  logic             target_tx_busy,
  input  logic             tx_push,
  input  logic [DW-1:0]    tx_push_data,
  output logic             tx_out_valid,
  output logic [DW-1:0]    tx_out_data,
  input  logic             tx_out_ready,
  input  logic             rx_push,
  input  logic [DW-1:0]    rx_push_data,
  input  logic             rx_pop,
  output logic [DW-1:0]    rx_rd_data,
  output logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] rx_level,
  output logic [5:0]       status,
  output logic [4:0]       raw_irq,
  output logic [4:0]       masked_irq,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  logic             flush;
  logic [LVL_W-1:0] tx_thr_q, rx_thr_q;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_ovf, tx_udf_unused, rx_ovf, rx_udf;
  logic [DW-1:0]    rx_head;
  logic [IRQ_W-1:0] evt;

  assign flush = ~enable;

  // thresholds are locked while the unit runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (!enable) begin
      if (tx_thr_we) tx_thr_q <= tx_thr_wdata;
      if (rx_thr_we) rx_thr_q <= rx_thr_wdata;
    end
  end

  sfh_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .push          (tx_push),
    .push_data     (tx_push_data),
    .pop           (tx_out_ready),
    .head          (tx_out_data),
    .full          (tx_full),
    .empty         (tx_empty),
    .level         (tx_level),
    .overflow_evt  (tx_ovf),
    .underflow_evt (tx_udf_unused)
  );

  sfh_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .push          (rx_push),
    .push_data     (rx_push_data),
    .pop           (rx_pop),
    .head          (rx_head),
    .full          (rx_full),
    .empty         (rx_empty),
    .level         (rx_level),
    .overflow_evt  (rx_ovf),
    .underflow_evt (rx_udf)
  );

  assign tx_out_valid = ~tx_empty;
  assign rx_rd_data   = rx_empty ? '0 : rx_head;

  always_comb begin
    evt             = '0;
    evt[IRQ_TX_OVF] = tx_ovf;
    evt[IRQ_RX_UDF] = rx_udf;
    evt[IRQ_RX_OVF] = rx_ovf;
  end

  sfh_irq #(.LVL_W(LVL_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_thr   (tx_thr_q),
    .rx_thr   (rx_thr_q),
    .evt      (evt),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .mask     (irq_mask),
    .raw      (raw_irq),
    .masked   (masked_irq),
    .irq      (irq)
  );

  sfh_dma #(.LVL_W(LVL_W)) u_dma (
    .enable   (enable),
    .dma_en   (dma_en),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_lvl   (tx_dma_lvl),
    .rx_lvl   (rx_dma_lvl),
    .tx_req   (tx_dma_req),
    .rx_req   (rx_dma_req)
  );

  always_comb begin
    status              = '0;
    status[ST_BUSY]     = enable & (engine_busy | ~tx_empty);
    status[ST_TX_FULL]  = tx_full;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_RX_EMPTY] = rx_empty;
    status[ST_RX_FULL]  = rx_full;
    status[ST_TGT_BUSY] = target_tx_busy;
  end

  AST_TX_THR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_thr_we) |=> $stable(tx_thr_q)); // R11

  AST_RX_THR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_thr_we) |=> $stable(rx_thr_q)); // R11
endmodule

// File: tb/spi_fifo_hub_tb_top.sv
module spi_fifo_hub_tb_top;
  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             enable = 0, tx_thr_we = 0, rx_thr_we = 0, clr_we = 0;
  logic [LVL_W-1:0] tx_thr_wdata = '0, rx_thr_wdata = '0, tx_dma_lvl = '0, rx_dma_lvl = '0;
  logic [4:0]       irq_mask = '0;
  logic [3:0]       clr_data = '0;
  logic [1:0]       dma_en = '0;
  logic             engine_busy = 0, target_tx_busy = 0;
  logic             tx_push = 0, tx_out_ready = 0, rx_push = 0, rx_pop = 0;
  logic [DW-1:0]    tx_push_data = '0, rx_push_data = '0;
  logic             tx_out_valid, irq, tx_dma_req, rx_dma_req;
  logic [DW-1:0]    tx_out_data, rx_rd_data;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic [5:0]       status;
  logic [4:0]       raw_irq, masked_irq;

  int n_tests = 0;
  int n_fail  = 0;

  spi_fifo_hub #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .tx_thr_we(tx_thr_we), .tx_thr_wdata(tx_thr_wdata),
    .rx_thr_we(rx_thr_we), .rx_thr_wdata(rx_thr_wdata),
    .irq_mask(irq_mask), .clr_we(clr_we), .clr_data(clr_data),
    .dma_en(dma_en), .tx_dma_lvl(tx_dma_lvl), .rx_dma_lvl(rx_dma_lvl),
    .engine_busy(engine_busy), .target_tx_busy(target_tx_busy),
    .tx_push(tx_push), .tx_push_data(tx_push_data),
    .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
    .rx_push(rx_push), .rx_push_data(rx_push_data),
    .rx_pop(rx_pop), .rx_rd_data(rx_rd_data),
    .tx_level(tx_level), .rx_level(rx_level), .status(status),
    .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one clock: inputs held across the rising edge, sampled after it
  task automatic tick();
    @(negedge clk);
    tx_push = 0; tx_out_ready = 0; rx_push = 0; rx_pop = 0;
    clr_we = 0; tx_thr_we = 0; rx_thr_we = 0;
    #1;
  endtask

  // op codes: 0 idle, 1 tx push, 2 engine tx take, 3 rx push, 4 bus rx pop, 5 clear
  // row: op[39:37] data[36:21] tx_level[20:13] rx_level[12:5] raw[4:0]
  // tx threshold 2, rx threshold 3
  localparam logic [39:0] TBL [18] = '{
    {3'd1, 16'h1111, 8'd1, 8'd0, 5'h01},  // R2 R7
    {3'd1, 16'h2222, 8'd2, 8'd0, 5'h01},  // R7 at threshold
    {3'd1, 16'h3333, 8'd3, 8'd0, 5'h00},  // R7 above threshold
    {3'd2, 16'h1111, 8'd2, 8'd0, 5'h01},  // R2 order
    {3'd3, 16'hA001, 8'd2, 8'd1, 5'h01},
    {3'd3, 16'hA002, 8'd2, 8'd2, 5'h01},
    {3'd3, 16'hA003, 8'd2, 8'd3, 5'h01},  // R6 level equal to threshold
    {3'd3, 16'hA004, 8'd2, 8'd4, 5'h11},  // R6 strictly greater
    {3'd4, 16'hA001, 8'd2, 8'd3, 5'h01},
    {3'd4, 16'hA002, 8'd2, 8'd2, 5'h01},
    {3'd4, 16'hA003, 8'd2, 8'd1, 5'h01},
    {3'd4, 16'hA004, 8'd2, 8'd0, 5'h01},
    {3'd4, 16'h0000, 8'd2, 8'd0, 5'h05},  // R4 underflow returns zero
    {3'd5, 16'h0002, 8'd2, 8'd0, 5'h01},  // R8 single clear
    {3'd4, 16'h0000, 8'd2, 8'd0, 5'h05},  // R4
    {3'd5, 16'h0001, 8'd2, 8'd0, 5'h01},  // R8 clear all
    {3'd2, 16'h2222, 8'd1, 8'd0, 5'h01},
    {3'd2, 16'h3333, 8'd0, 8'd0, 5'h01}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", status, 6'h0C);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 raw_irq", raw_irq, 5'h01);
    chk("R1 irq/dma", {irq, tx_dma_req, rx_dma_req}, 3'b000);

    // program thresholds while disabled (R11)
    @(negedge clk);
    tx_thr_we = 1; tx_thr_wdata = 2; rx_thr_we = 1; rx_thr_wdata = 3;
    tick();
    @(negedge clk); enable = 1; #1;

    // table walk: R2 R4 R6 R7 R8
    foreach (TBL[i]) begin
      logic [2:0]  op;
      logic [15:0] d;
      op = TBL[i][39:37];
      d  = TBL[i][36:21];
      @(negedge clk);
      case (op)
        3'd1: begin tx_push = 1; tx_push_data = d; end
        3'd2: tx_out_ready = 1;
        3'd3: begin rx_push = 1; rx_push_data = d; end
        3'd4: rx_pop = 1;
        3'd5: begin clr_we = 1; clr_data = d[3:0]; end
        default: ;
      endcase
      #1;
      if (op == 3'd2) chk($sformatf("R2 table row %0d tx head", i), tx_out_data, d);
      if (op == 3'd4) chk($sformatf("R2 R4 table row %0d rx data", i), rx_rd_data, d);
      tick();
      chk($sformatf("R2 R6 R7 R8 table row %0d", i),
          {8'(tx_level), 8'(rx_level), raw_irq}, TBL[i][20:0]);
    end

    // R11: threshold write while enabled is ignored
    @(negedge clk); rx_thr_we = 1; rx_thr_wdata = 0; tick();
    @(negedge clk); rx_push = 1; rx_push_data = 16'h5555; tick();
    chk("R11 rx threshold locked", raw_irq[4], 1'b0);
    @(negedge clk); rx_pop = 1; tick();
    chk("R11 rx drained", rx_level, 0);

    // R9 mask and combined line
    @(negedge clk); irq_mask = 5'h01; #1;
    chk("R9 masked", {masked_irq, irq}, {5'h01, 1'b1});
    irq_mask = 5'h10; #1;
    chk("R9 masked off", {masked_irq, irq}, {5'h00, 1'b0});
    irq_mask = 5'h00;

    // R13 status bits
    engine_busy = 1; target_tx_busy = 1; #1;
    chk("R13 status busy", status, 6'h2D);
    engine_busy = 0; target_tx_busy = 0; #1;
    chk("R13 status idle", status, 6'h0C);

    // R12 DMA requests
    dma_en = 2'b11; tx_dma_lvl = 1; rx_dma_lvl = 0; #1;
    chk("R12 dma empty", {tx_dma_req, rx_dma_req}, 2'b10);
    @(negedge clk); rx_push = 1; rx_push_data = 16'hC001; tick();
    chk("R12 rx req", rx_dma_req, 1'b1);
    rx_dma_lvl = 1; #1;
    chk("R12 rx req boundary", rx_dma_req, 1'b0);
    @(negedge clk); tx_push = 1; tx_push_data = 16'hB001; tick();
    chk("R12 tx req at level", tx_dma_req, 1'b1);
    @(negedge clk); tx_push = 1; tx_push_data = 16'hB002; tick();
    chk("R12 tx req above", tx_dma_req, 1'b0);
    dma_en = 2'b00; rx_dma_lvl = 0; #1;
    chk("R12 dma disabled", {tx_dma_req, rx_dma_req}, 2'b00);

    // R3 transmit overflow
    for (int k = 0; k < DEPTH - 2; k++) begin
      @(negedge clk); tx_push = 1; tx_push_data = 16'(k); tick();
    end
    chk("R3 tx full", {8'(tx_level), status[1]}, {8'(DEPTH), 1'b1});
    @(negedge clk); tx_push = 1; tx_push_data = 16'hDEAD; tick();
    chk("R3 tx overflow", {8'(tx_level), raw_irq[1], tx_out_data}, {8'(DEPTH), 1'b1, 16'hB001});
    @(negedge clk); tx_push = 1; clr_we = 1; clr_data = 4'h8; tick();
    chk("R8 set beats clear", raw_irq[1], 1'b1);
    @(negedge clk); clr_we = 1; clr_data = 4'h8; tick();
    chk("R8 tx overflow cleared", raw_irq[1], 1'b0);

    // R5 receive overflow
    for (int k = 0; k < DEPTH - 1; k++) begin
      @(negedge clk); rx_push = 1; rx_push_data = 16'(k); tick();
    end
    chk("R5 rx full", {8'(rx_level), status[4]}, {8'(DEPTH), 1'b1});
    @(negedge clk); rx_push = 1; rx_push_data = 16'hBEEF; tick();
    chk("R5 rx overflow", {8'(rx_level), raw_irq[3], rx_rd_data}, {8'(DEPTH), 1'b1, 16'hC001});
    @(negedge clk); clr_we = 1; clr_data = 4'h4; tick();
    chk("R8 rx overflow cleared", raw_irq[3], 1'b0);

    // R10 disable flush
    @(negedge clk); enable = 0; tick();
    chk("R10 flushed", {8'(tx_level), 8'(rx_level), status}, {8'd0, 8'd0, 6'h0C});
    @(negedge clk); tx_push = 1; tx_push_data = 16'h7777; tick();
    chk("R10 push ignored", {8'(tx_level), raw_irq[1]}, {8'd0, 1'b0});

    // R11 threshold accepted while disabled
    @(negedge clk); rx_thr_we = 1; rx_thr_wdata = 0; tick();
    @(negedge clk); enable = 1; rx_push = 1; rx_push_data = 16'h1234; tick();
    chk("R11 R6 new threshold", raw_irq[4], 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule